// File: doc/BRIEF.md
# Write-Once System Option Register

This block is a single 8-bit, memory-mapped option register. It sets how the chip is configured while it starts up. A simple bus with one address, a write strobe, write data and read data reaches it. The register drives five static configuration outputs:

- the external interrupt sense (level or edge only);
- the enable for a long recovery delay on wake from stop;
- the clock monitor enable;
- a 2-bit watchdog rate code;
- a one-hot divider select decoded from that code.

Four of the bits are guarded:

- In normal mode the interrupt-sense bit, the wake-delay bit and both rate bits take only one write. That write must land inside a short window after reset. After that the four bits are frozen until the next reset.
- In special mode the guard is lifted and those bits may be rewritten at any time.
- The clock monitor enable is never guarded.

The block also times the recovery after stop. While the stop request is asserted, the ready output stays low. Once the request is released, ready stays low for a long or a short count, chosen by the wake-delay bit, and then goes high.

Top module: `sysopt_reg`

## Requirements
- R1: After reset the register reads 0x10: wake-delay enable 1, every other bit 0, ready high while stop is not requested.
- R2: Bit 5 is the interrupt sense (0 level, 1 edge only), bit 4 the wake-delay enable, bit 3 the clock monitor enable and bits 1:0 the watchdog rate. Each output mirrors its bit.
- R3: Bits 7, 6 and 2 always read 0, and writing them has no effect.
- R4: In normal mode, the first register write inside the window updates bits 5, 4, 1 and 0, and locks them. This holds even when the written value equals the reset value. Later writes leave those bits unchanged.
- R5: The window is the first WINDOW_CYCLES (default 64) clock cycles after reset. In normal mode, a write on cycle 63 after reset (counted from 0) is accepted. A write on cycle 64 or later leaves the guarded bits unchanged.
- R6: In special mode (special_mode_i = 1), bits 5, 4, 1 and 0 can be written any number of times at any time, and such writes do not lock them.
- R7: Bit 3 (clock monitor enable) takes every register write, in both modes and at any time.
- R8: Writes to any address other than REG_ADDR have no effect. Reads from any other address return 0x00.
- R9: wdog_div_sel_o is one-hot, with bit k set for rate code k. Codes 0, 1, 2 and 3 select extra watchdog divides of 1, 4, 16 and 64.
- R10: ready_o is low while stop_req_i is 1. After stop_req_i falls, ready_o rises on the LONG_DELAY-th rising edge (default 4000) if bit 4 is 1. It rises on the SHORT_DELAY-th edge (default 4) if bit 4 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| special_mode_i | input | 1 | 1 lifts the write-once guard |
| bus_addr_i | input | ADDR_W | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, 0 unless the address matches |
| stop_req_i | input | 1 | Stop request; its falling edge starts recovery |
| irq_edge_o | output | 1 | 1 edge-only interrupt sense, 0 level |
| wake_delay_en_o | output | 1 | Long recovery delay selected |
| clkmon_en_o | output | 1 | Clock monitor enable |
| wdog_rate_o | output | 2 | Watchdog rate code |
| wdog_div_sel_o | output | 4 | One-hot extra watchdog divider select |
| ready_o | output | 1 | High when the core may resume |

## Verification
The hardest cases to reach are the two edges of the write window in normal mode. One is a write on the last open cycle. The other is a write one cycle later, which must be refused. A third is a lock taken by a write that changes no value.

The bench reaches these cases with fresh resets. Each is followed by an exact count of idle cycles (63 and 64) before the write, and by a write of the reset value followed by a differing value.

Randomized traffic then mixes the modes, addresses, writes and occasional resets. A cycle-accurate model tracks the window, the lock and the register contents.

// File: rtl/sysopt_pkg.sv
package sysopt_pkg;
  localparam int unsigned CFG_W      = 8;
  localparam int unsigned IRQ_BIT    = 5;
  localparam int unsigned DELAY_BIT  = 4;
  localparam int unsigned CLKMON_BIT = 3;
  localparam int unsigned RATE_LSB   = 0;
  localparam int unsigned RATE_W     = 2;
  localparam int unsigned SEL_W      = 1 << RATE_W;

  typedef logic [CFG_W-1:0] cfg_byte_t;

  // bits writable once in normal mode
  localparam cfg_byte_t GUARD_MASK = cfg_byte_t'(8'h33);
  // bits writable at all times
  localparam cfg_byte_t FREE_MASK  = cfg_byte_t'(8'h08);
  localparam cfg_byte_t RESET_VAL  = cfg_byte_t'(8'h10);
endpackage

// File: rtl/sysopt_window.sv
module sysopt_window #(
  parameter int unsigned WINDOW_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_req_i,
  output logic open_o,
  output logic locked_o
);
  localparam int unsigned CNT_W = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WINDOW_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lock_q, lock_d;
  logic             cnt_en;

  assign open_o   = (cnt_q != CNT_MAX);
  assign locked_o = lock_q;
  assign cnt_en   = open_o;

  always_comb begin
    cnt_d  = cnt_q;
    lock_d = lock_q;
    if (cnt_en) cnt_d = cnt_q + CNT_W'(1);
    if (lock_req_i && open_o) lock_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end
endmodule

// File: rtl/sysopt_wake_delay.sv
module sysopt_wake_delay #(
  parameter int unsigned LONG_DELAY  = 4000,
  parameter int unsigned SHORT_DELAY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_req_i,
  input  logic long_sel_i,
  output logic ready_o
);
  localparam int unsigned CNT_W = $clog2(LONG_DELAY + 1);
  localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_DELAY);
  localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_DELAY);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign ready_o  = !stop_req_i && cnt_zero;

  always_comb begin
    cnt_d = cnt_q;
    if (stop_req_i)     cnt_d = long_sel_i ? LONG_LD : SHORT_LD;
    else if (!cnt_zero) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sysopt_rate_decode.sv
module sysopt_rate_decode
  import sysopt_pkg::*;
(
  input  logic [RATE_W-1:0] rate_i,
  output logic [SEL_W-1:0]  sel_o
);
  for (genvar g = 0; g < SEL_W; g++) begin : g_sel
    assign sel_o[g] = (rate_i == RATE_W'(g));
  end
endmodule

// File: rtl/sysopt_reg.sv
module sysopt_reg
  import sysopt_pkg::*;
#(
  parameter int unsigned ADDR_W        = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h20,
  parameter int unsigned WINDOW_CYCLES = 64,
  parameter int unsigned LONG_DELAY    = 4000,
  parameter int unsigned SHORT_DELAY   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              special_mode_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  input  logic              stop_req_i,
  output logic              irq_edge_o,
  output logic              wake_delay_en_o,
  output logic              clkmon_en_o,
  output logic [1:0]        wdog_rate_o,
  output logic [3:0]        wdog_div_sel_o,
  output logic              ready_o
);
  cfg_byte_t cfg_q, cfg_d;
  cfg_byte_t wr_mask;
  logic      hit, wr_hit, win_open, locked, guard_ok, lock_req;

  assign hit      = (bus_addr_i == REG_ADDR);
  assign wr_hit   = hit && bus_we_i;
  assign guard_ok = special_mode_i || (win_open && !locked);
  assign lock_req = wr_hit && !special_mode_i;
  assign wr_mask  = FREE_MASK | (guard_ok ? GUARD_MASK : '0);

  sysopt_window #(.WINDOW_CYCLES(WINDOW_CYCLES)) win_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lock_req_i (lock_req),
    .open_o     (win_open),
    .locked_o   (locked)
  );

  always_comb begin
    cfg_d = cfg_q;
    if (wr_hit) cfg_d = (cfg_q & ~wr_mask) | (bus_wdata_i & wr_mask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= RESET_VAL;
    else         cfg_q <= cfg_d;
  end

  assign bus_rdata_o     = hit ? cfg_q : '0;
  assign irq_edge_o      = cfg_q[IRQ_BIT];
  assign wake_delay_en_o = cfg_q[DELAY_BIT];
  assign clkmon_en_o     = cfg_q[CLKMON_BIT];
  assign wdog_rate_o     = cfg_q[RATE_LSB +: RATE_W];

  sysopt_rate_decode dec_i (
    .rate_i (wdog_rate_o),
    .sel_o  (wdog_div_sel_o)
  );

  sysopt_wake_delay #(
    .LONG_DELAY  (LONG_DELAY),
    .SHORT_DELAY (SHORT_DELAY)
  ) wake_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stop_req_i (stop_req_i),
    .long_sel_i (wake_delay_en_o),
    .ready_o    (ready_o)
  );
endmodule

// File: rtl/sysopt_reg_chk.sv
module sysopt_reg_chk #(
  parameter int unsigned ADDR_W        = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h20,
  parameter int unsigned WINDOW_CYCLES = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              special_mode_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [7:0]        bus_rdata_o,
  input logic              stop_req_i,
  input logic              irq_edge_o,
  input logic              wake_delay_en_o,
  input logic [1:0]        wdog_rate_o,
  input logic [3:0]        wdog_div_sel_o,
  input logic              ready_o
);
  localparam int unsigned CW = $clog2(WINDOW_CYCLES + 1);
  logic [CW-1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cyc_q <= '0;
    else if (cyc_q != CW'(WINDOW_CYCLES)) cyc_q <= cyc_q + CW'(1);
  end

  a_r3_unimpl_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rdata_o[7:6] == 2'b00) && !bus_rdata_o[2]);

  a_r2_irq_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == REG_ADDR) |-> (bus_rdata_o[5] == irq_edge_o && bus_rdata_o[4] == wake_delay_en_o));

  a_r5_frozen_after_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == CW'(WINDOW_CYCLES) && !special_mode_i) |=>
      $stable({irq_edge_o, wake_delay_en_o, wdog_rate_o}));

  a_r9_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wdog_div_sel_o) == 1 && wdog_div_sel_o[wdog_rate_o]);

  a_r10_stop_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_req_i |-> !ready_o);

  a_r10_ready_falls_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> stop_req_i);
endmodule

bind sysopt_reg sysopt_reg_chk #(
  .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .WINDOW_CYCLES(WINDOW_CYCLES)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .special_mode_i(special_mode_i),
  .bus_addr_i(bus_addr_i), .bus_rdata_o(bus_rdata_o), .stop_req_i(stop_req_i),
  .irq_edge_o(irq_edge_o), .wake_delay_en_o(wake_delay_en_o),
  .wdog_rate_o(wdog_rate_o), .wdog_div_sel_o(wdog_div_sel_o), .ready_o(ready_o)
);

// File: tb/sysopt_reg_tb.sv
module sysopt_reg_tb_top;
  localparam logic [7:0] RADDR = 8'h20;
  localparam int WIN = 64, LDLY = 4000, SDLY = 4;

  logic clk = 1'b0, rst_n = 1'b0, special = 1'b0, we = 1'b0, stop = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic irq_edge, dly_en, cme, ready;
  logic [1:0] rate;
  logic [3:0] div_sel;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sysopt_reg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .special_mode_i(special),
    .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .stop_req_i(stop), .irq_edge_o(irq_edge), .wake_delay_en_o(dly_en),
    .clkmon_en_o(cme), .wdog_rate_o(rate), .wdog_div_sel_o(div_sel), .ready_o(ready)
  );

  // requirement-level model of the register
  logic [7:0] m_reg;
  bit m_lock;
  int m_cyc;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg <= 8'h10; m_lock <= 0; m_cyc <= 0;
    end else begin
      if (m_cyc < WIN) m_cyc <= m_cyc + 1;
      if (we && addr == RADDR) begin
        logic [7:0] msk;
        msk = 8'h08;
        if (special || (m_cyc < WIN && !m_lock)) msk = msk | 8'h33;
        m_reg <= (m_reg & ~msk) | (wdata & msk);
        if (!special && m_cyc < WIN) m_lock <= 1;
      end
    end
  end

  function automatic logic [3:0] exp_sel(input logic [1:0] r);
    return 4'b0001 << r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; we = 0; stop = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0; addr = RADDR;
  endtask

  // reads at a negedge, checks readback and outputs against model and an explicit value
  task automatic rd_check(input string req, input logic [7:0] exp);
    addr = RADDR; we = 0; #1;
    chk(req, rdata, exp);
    chk(req, rdata, m_reg);
    chk(req, {irq_edge, dly_en, cme, rate}, {exp[5], exp[4], exp[3], exp[1:0]});
    chk("R9", div_sel, exp_sel(exp[1:0]));
  endtask

  task automatic wake(input int expn, input string req);
    int n = 0;
    stop = 1; repeat (3) @(negedge clk);
    chk(req, ready, 1'b0);
    stop = 0;
    while (n < LDLY + 100) begin
      @(negedge clk); n++;
      if (ready) break;
    end
    chk(req, n, expn);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    do_reset();
    // R1: reset value
    rd_check("R1", 8'h10);
    chk("R1", ready, 1'b1);
    // R4: lock taken by write equal to reset value
    wr(RADDR, 8'h10); rd_check("R4", 8'h10);
    wr(RADDR, 8'h33); rd_check("R4", 8'h10);
    // R7: clock monitor still writable after lock
    wr(RADDR, 8'h08); rd_check("R7", 8'h18);
    wr(RADDR, 8'h00); rd_check("R7", 8'h10);
    // R5: last open cycle accepted, R3 unimplemented bits dropped
    do_reset(); repeat (63) @(negedge clk);
    wr(RADDR, 8'hFF); rd_check("R5", 8'h3B); rd_check("R3", 8'h3B);
    // R5: first closed cycle refused
    do_reset(); repeat (64) @(negedge clk);
    wr(RADDR, 8'hE7); rd_check("R5", 8'h10);
    // R8: other address
    do_reset();
    wr(8'h21, 8'hFF); rd_check("R8", 8'h10);
    addr = 8'h07; #1; chk("R8", rdata, 8'h00);
    @(negedge clk);
    // R6: special mode rewrites at any time
    special = 1; do_reset(); repeat (100) @(negedge clk);
    wr(RADDR, 8'h21); rd_check("R6", 8'h21);
    wr(RADDR, 8'h02); rd_check("R6", 8'h02);
    // R2/R9: each rate code and bit placement
    for (int k = 0; k < 4; k++) begin
      wr(RADDR, 8'h20 | 8'(k)); rd_check("R2", 8'h20 | 8'(k));
    end
    // R10: short then long recovery
    wr(RADDR, 8'h00); wake(SDLY, "R10");
    wr(RADDR, 8'h10); wake(LDLY, "R10");
    special = 0;
    // randomized traffic against the model
    void'($urandom(32'h5EED_0011));
    do_reset();
    for (int i = 0; i < 2000; i++) begin
      if ($urandom_range(0, 199) == 0) do_reset();
      special = ($urandom_range(0, 9) == 0);
      addr = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 255)) : RADDR;
      wdata = 8'($urandom); we = $urandom_range(0, 1);
      @(negedge clk); we = 0; addr = RADDR; #1;
      chk("R4", rdata, m_reg);
      chk("R9", div_sel, exp_sel(m_reg[1:0]));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule